// File: doc/BRIEF.md
# Configuration Memory Integrity Checker

This block guards a configuration memory against silent bit upsets. While the memory is being filled, it watches the same word stream and folds it into a 32-bit CRC. When the last word arrives, it keeps that CRC as the golden reference and switches to its running phase. From then on it reads the memory back through a simple read port, one word per cycle, in an endless loop. At the end of every full pass it compares the recomputed CRC with the reference. A mismatch raises an error flag that stays set until reset. The flag is also presented as an open-drain enable.

A host can check the error path without refilling the memory. It selects the reference register through a decoded test instruction, shifts a chosen 32-bit value into a shift stage, and then applies an update strobe. The update replaces the live reference. If the value is wrong, the next compare must fail. The TAP state machine lies outside this block: the instruction register value and the shift and update strobes arrive as inputs.

Top module: `cram_crc_monitor`

## Requirements
- R1: While reset is held, `crc_err` is 0, `err_od_oe` is 1, `rd_addr` is 0 and `tap_tdo` is 0.
- R2: The CRC uses polynomial 0x04C11DB7, non-reflected, with an all-ones seed and no final inversion. Each 32-bit word is folded in from bit 31 down to bit 0. One engine serves both the load phase and the running phase.
- R3: In the load phase, every cycle with `ld_valid` high folds `ld_data` into the CRC. The cycle with `ld_valid` and `ld_last` both high stores the CRC, including that word, as the reference. The running phase starts on the next cycle.
- R4: In the running phase, `rd_addr` steps through 0, 1, …, DEPTH-1 one step per cycle and then wraps to 0. `rd_data` is taken in the same cycle as `rd_addr` (combinational read). In the load phase `rd_addr` stays at 0.
- R5: On the cycle at address DEPTH-1, the CRC of the pass just completed is compared with the reference, and the CRC restarts from all ones. A mismatch sets `crc_err` on the next clock edge. A match leaves it unchanged.
- R6: Once set, `crc_err` stays high until reset, even after the memory content is correct again.
- R7: Shift and update strobes act only while `tap_ir` equals 10'b00_0001_0101. With any other code they have no effect.
- R8: With that code selected in the running phase, each `tap_shift` cycle moves `tap_tdi` into bit 31 of the shift stage and shifts it right. `tap_tdo` always shows bit 0 of the shift stage. After 32 shifts, `tap_tdo` equals the first bit shifted in.
- R9: A `tap_update` cycle with the code selected in the running phase copies the shift stage into the reference. Every later compare uses the new value.
- R10: During the load phase, shift and update strobes are ignored, whatever the code: the shift stage and the reference are left untouched.
- R11: `err_od_oe` is the inverse of `crc_err`. A value of 1 pulls the line low; a value of 0 releases it.
- R12: In the running phase, `ld_valid`, `ld_last` and `ld_data` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | Load-phase word valid |
| ld_last | input | 1 | Marks the final load word |
| ld_data | input | DATA_W | Load-phase word |
| rd_addr | output | $clog2(DEPTH) | Memory read address |
| rd_data | input | DATA_W | Memory read data, same cycle as address |
| tap_ir | input | IR_W | Decoded instruction register value |
| tap_shift | input | 1 | Shift strobe for the selected data register |
| tap_update | input | 1 | Update strobe for the selected data register |
| tap_tdi | input | 1 | Serial test data in |
| tap_tdo | output | 1 | Serial test data out (shift stage bit 0) |
| crc_err | output | 1 | Sticky mismatch flag, active high |
| err_od_oe | output | 1 | Open-drain enable for the error line (1 pulls low) |

## Verification
The hardest situation to reach from the ports is a compare that fails only because the reference was replaced at run time, not because the memory changed. The bench gets there by completing a clean load and several passes, then shifting a deliberately wrong reference through the test path while the memory stays untouched. A behavioural model reproduces every pass boundary cycle by cycle, so the error must rise on exactly the right edge. A bit flip in the middle of a pass is handled the same way, and the model predicts whether the first or second compare catches it.

// File: rtl/cram_crc_pkg.sv
// Shared constants and types for the configuration-memory CRC checker.
// Assumes a 32-bit CRC; the polynomial and seed are fixed here.
package cram_crc_pkg;
    localparam int          CRC_W    = 32;
    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

    typedef enum logic {
        PH_LOAD = 1'b0,
        PH_RUN  = 1'b1
    } phase_t;
endpackage

// File: rtl/crc_word_engine.sv
// Combinational CRC step: folds one DATA_W-bit word into a 32-bit CRC,
// from the word's MSB down to its LSB, non-reflected.
// Assumes the caller holds the running CRC in a register.
module crc_word_engine
    import cram_crc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);
    // Bit-serial fold, unrolled over the word width.
    always_comb begin
        logic [CRC_W-1:0] c;
        logic             fb;
        c = crc_in;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ data_in[i];
            c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        crc_out = c;
    end
endmodule

// File: rtl/cram_scanner.sv
// Read-address sequencer: walks 0..DEPTH-1 once per pass and wraps, while run is high.
// Holds address 0 while run is low. Assumes DEPTH >= 2.
module cram_scanner #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    output logic [AW-1:0] addr,
    output logic          last
);
    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    logic [AW-1:0] addr_q;

    // Address counter with a wrap at the last word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (run) begin
            addr_q <= (addr_q == LAST_ADDR) ? '0 : addr_q + 1'b1;
        end
    end

    assign addr = addr_q;
    assign last = run && (addr_q == LAST_ADDR);

    // R4: step by one while running and not at the end
    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && addr_q != LAST_ADDR) |=> (addr_q == AW'($past(addr_q) + 1'b1)));
    // R4: wrap to zero after the final word
    a_r4_addr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run && addr_q == LAST_ADDR) |=> (addr_q == '0));
    // R4: idle at zero during the load phase
    a_r4_addr_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (addr_q == '0));
endmodule

// File: rtl/ref_test_reg.sv
// Reference CRC holder plus a serial test data register.
// Load capture writes the reference at the end of the load phase; in the running
// phase a selected shift moves TDI in LSB-first and update copies the shift stage
// into the reference. Assumes capture and update never coincide.
module ref_test_reg
    import cram_crc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             sel,
    input  logic             shift,
    input  logic             update,
    input  logic             tdi,
    input  logic             cap_en,
    input  logic [CRC_W-1:0] cap_val,
    output logic [CRC_W-1:0] ref_crc,
    output logic             tdo
);
    logic [CRC_W-1:0] sr_q;
    logic [CRC_W-1:0] ref_q;
    logic             shift_en;
    logic             update_en;

    assign shift_en  = run && sel && shift;
    assign update_en = run && sel && update;

    // Live reference: load capture, then test-path update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= '0;
        end else if (cap_en) begin
            ref_q <= cap_val;
        end else if (update_en) begin
            ref_q <= sr_q;
        end
    end

    // Shift stage: LSB leaves on TDO, TDI enters at the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (shift_en) begin
            sr_q <= {tdi, sr_q[CRC_W-1:1]};
        end
    end

    assign ref_crc = ref_q;
    assign tdo     = sr_q[0];

    // R10: the shift stage is frozen during the load phase
    a_r10_load_sr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(sr_q));
    // R7: without the selecting code the shift stage cannot move
    a_r7_unselected_sr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> $stable(sr_q));
    // R9: an update in the running phase lands the shift stage in the reference
    a_r9_update_copies: assert property (@(posedge clk) disable iff (!rst_n)
        update_en |=> (ref_q == $past(sr_q)));
endmodule

// File: rtl/cram_crc_monitor.sv
// Top level: configuration memory CRC checker.
// Load phase: folds the incoming load stream into a CRC and keeps it as reference.
// Running phase: rereads the memory in a loop, compares at each pass end, and
// latches a sticky error. Assumes a combinational memory read port.
module cram_crc_monitor
    import cram_crc_pkg::*;
#(
    parameter int              DATA_W = 32,
    parameter int              DEPTH  = 16,
    parameter int              IR_W   = 10,
    parameter logic [IR_W-1:0] IR_SEL = 10'b00_0001_0101
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ld_valid,
    input  logic                     ld_last,
    input  logic [DATA_W-1:0]        ld_data,
    output logic [$clog2(DEPTH)-1:0] rd_addr,
    input  logic [DATA_W-1:0]        rd_data,
    input  logic [IR_W-1:0]          tap_ir,
    input  logic                     tap_shift,
    input  logic                     tap_update,
    input  logic                     tap_tdi,
    output logic                     tap_tdo,
    output logic                     crc_err,
    output logic                     err_od_oe
);
    localparam int AW = $clog2(DEPTH);

    phase_t           phase_q;
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_next;
    logic [CRC_W-1:0] ref_crc;
    logic [DATA_W-1:0] eng_data;
    logic             running;
    logic             scan_last;
    logic             capture;
    logic             err_q;
    logic             sel;
    logic [AW-1:0]    scan_addr;

    assign running  = (phase_q == PH_RUN);
    assign capture  = !running && ld_valid && ld_last;
    assign sel      = (tap_ir == IR_SEL);
    assign eng_data = running ? rd_data : ld_data;

    crc_word_engine #(.DATA_W(DATA_W)) u_engine (
        .crc_in  (crc_q),
        .data_in (eng_data),
        .crc_out (crc_next)
    );

    cram_scanner #(.DEPTH(DEPTH), .AW(AW)) u_scan (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .addr  (scan_addr),
        .last  (scan_last)
    );

    ref_test_reg u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (running),
        .sel     (sel),
        .shift   (tap_shift),
        .update  (tap_update),
        .tdi     (tap_tdi),
        .cap_en  (capture),
        .cap_val (crc_next),
        .ref_crc (ref_crc),
        .tdo     (tap_tdo)
    );

    // Phase register: leaves the load phase on the final load word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_LOAD;
        end else if (capture) begin
            phase_q <= PH_RUN;
        end
    end

    // Running CRC: folds load words or read words, reseeds at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= CRC_SEED;
        end else if (running) begin
            crc_q <= scan_last ? CRC_SEED : crc_next;
        end else if (ld_valid) begin
            crc_q <= ld_last ? CRC_SEED : crc_next;
        end
    end

    // Sticky error: set by a failed compare at a pass end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (scan_last && (crc_next != ref_crc)) begin
            err_q <= 1'b1;
        end
    end

    assign rd_addr   = scan_addr;
    assign crc_err   = err_q;
    assign err_od_oe = !err_q;

    // R6: the error flag never clears outside reset
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
    // R5: the flag rises only right after a pass-end compare
    a_r5_err_rise_at_pass_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $past(scan_last));
    // R3: the running phase, once entered, is kept
    a_r3_run_kept: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);
    // R11: line released exactly when an error is flagged
    a_r11_od_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $fell(err_od_oe));
endmodule

// File: tb/cram_crc_monitor_tb.sv
module cram_crc_monitor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int AW         = $clog2(DEPTH);
    localparam logic [9:0] SEL_CODE = 10'b00_0001_0101;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ld_valid = 1'b0;
    logic             ld_last = 1'b0;
    logic [31:0]      ld_data = '0;
    logic [AW-1:0]    rd_addr;
    logic [31:0]      rd_data;
    logic [9:0]       tap_ir = '0;
    logic             tap_shift = 1'b0;
    logic             tap_update = 1'b0;
    logic             tap_tdi = 1'b0;
    logic             tap_tdo;
    logic             crc_err;
    logic             err_od_oe;

    logic [31:0] mem [DEPTH];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rd_data = mem[rd_addr];

    cram_crc_monitor #(.DATA_W(32), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ld_valid(ld_valid), .ld_last(ld_last), .ld_data(ld_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .tap_ir(tap_ir), .tap_shift(tap_shift), .tap_update(tap_update),
        .tap_tdi(tap_tdi), .tap_tdo(tap_tdo),
        .crc_err(crc_err), .err_od_oe(err_od_oe)
    );

    // CRC per the requirement text: poly 0x04C11DB7, MSB first, no reflection.
    function automatic logic [31:0] crc_w(logic [31:0] c, logic [31:0] d);
        logic fb;
        for (int i = 31; i >= 0; i--) begin
            fb = c[31] ^ d[i];
            c  = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
        end
        return c;
    endfunction

    function automatic logic [31:0] crc_of_mem();
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < DEPTH; i++) c = crc_w(c, mem[i]);
        return c;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model, advanced at every rising edge.
    bit          m_ok = 0;
    bit          m_run;
    int          m_addr;
    logic [31:0] m_crc, m_ref, m_sr, m_t;
    bit          m_err;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ok = 1; m_run = 0; m_addr = 0; m_crc = 32'hFFFF_FFFF;
            m_ref = '0; m_sr = '0; m_err = 0;
        end else if (m_ok) begin
            if (!m_run) begin
                if (ld_valid) begin
                    m_t = crc_w(m_crc, ld_data);
                    m_crc = m_t;
                    if (ld_last) begin
                        m_ref = m_t; m_run = 1; m_crc = 32'hFFFF_FFFF;
                    end
                end
            end else begin
                m_t = crc_w(m_crc, mem[m_addr]);
                if (m_addr == DEPTH - 1) begin
                    if (m_t != m_ref) m_err = 1;
                    m_crc = 32'hFFFF_FFFF; m_addr = 0;
                end else begin
                    m_crc = m_t; m_addr++;
                end
                if (tap_ir == SEL_CODE) begin
                    if (tap_update) m_ref = m_sr;
                    if (tap_shift) m_sr = {tap_tdi, m_sr[31:1]};
                end
            end
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (m_ok && !done) begin
            check("R4 rd_addr", 32'(rd_addr), 32'(m_addr));
            check("R5 crc_err", 32'(crc_err), 32'(m_err));
            check("R11 err_od_oe", 32'(err_od_oe), 32'(!m_err));
            check("R8 tap_tdo", 32'(tap_tdo), 32'(m_sr[0]));
        end
    end

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic load_mem();
        for (int i = 0; i < DEPTH; i++) begin
            if (i == 3) begin
                @(negedge clk); ld_valid = 0;
            end
            @(negedge clk);
            ld_valid = 1; ld_data = mem[i]; ld_last = (i == DEPTH - 1);
        end
        @(negedge clk); ld_valid = 0; ld_last = 0;
    endtask

    task automatic tap_load(logic [9:0] ir, logic [31:0] v);
        tap_ir = ir;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk); tap_shift = 1; tap_tdi = v[i];
        end
        @(negedge clk); tap_shift = 0; tap_update = 1;
        @(negedge clk); tap_update = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] good;
        for (int i = 0; i < DEPTH; i++) mem[i] = (32'h9E37_79B9 * (i + 1)) ^ (i << 5);

        // R1: reset values
        repeat (2) @(negedge clk);
        check("R1 crc_err", 32'(crc_err), 0);
        check("R1 err_od_oe", 32'(err_od_oe), 1);
        check("R1 rd_addr", 32'(rd_addr), 0);
        check("R1 tap_tdo", 32'(tap_tdo), 0);
        rst_n = 1;

        // R10: test path strobes during the load phase are ignored
        tap_load(SEL_CODE, 32'hFFFF_FFFF);
        check("R10 tdo after load-phase shift", 32'(tap_tdo), 0);

        load_mem();
        good = crc_of_mem();
        repeat (3 * DEPTH) @(negedge clk);
        check("R2 clean passes", 32'(crc_err), 0);
        check("R3 reference from load", 32'(crc_err), 0);

        // R7: other instruction codes do not reach the register
        tap_load(10'b00_0001_0100, 32'h1234_5677);
        check("R7 tdo unselected", 32'(tap_tdo), 0);
        repeat (2 * DEPTH) @(negedge clk);
        check("R7 no error after unselected update", 32'(crc_err), 0);

        // R8/R9: load the correct reference through the test path
        tap_load(SEL_CODE, good);
        check("R8 tdo shows first bit in", 32'(tap_tdo), 32'(good[0]));
        repeat (2 * DEPTH) @(negedge clk);
        check("R9 correct reference keeps clean", 32'(crc_err), 0);

        // R12: load inputs in the running phase
        @(negedge clk); ld_valid = 1; ld_last = 1; ld_data = 32'hDEAD_BEEF;
        repeat (3) @(negedge clk);
        ld_valid = 0; ld_last = 0;
        repeat (2 * DEPTH) @(negedge clk);
        check("R12 load ignored while running", 32'(crc_err), 0);

        // R5: single bit flip in memory
        @(negedge clk); mem[5] = mem[5] ^ 32'h0000_0001;
        repeat (2 * DEPTH) @(negedge clk);
        check("R5 flip detected", 32'(crc_err), 1);
        check("R11 line released", 32'(err_od_oe), 0);
        mem[5] = mem[5] ^ 32'h0000_0001;
        repeat (2 * DEPTH) @(negedge clk);
        check("R6 error sticky", 32'(crc_err), 1);

        // Second run: wrong reference injected, memory untouched
        do_reset();
        load_mem();
        repeat (2 * DEPTH) @(negedge clk);
        check("R3 clean after reload", 32'(crc_err), 0);
        tap_load(SEL_CODE, good ^ 32'h8000_0000);
        repeat (2 * DEPTH) @(negedge clk);
        check("R9 wrong reference flags error", 32'(crc_err), 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule